// File: doc/BRIEF.md
# Chip-Select Gated Command Register

This block is a one-to-one register for the command and address path of a memory module. On every rising clock edge it captures a wide data word, the on-die-termination bits, the clock-enable bits and the chip-select bits, and presents each as a registered output. The data outputs are gated by the chip selects. When every chip-select input is high, the data outputs keep their previous value. When any chip select is low, the data outputs take the new word. The termination, clock-enable and chip-select outputs are registered on every edge, whatever the chip-select state.

An active-low reset clears every register and forces all outputs low as soon as it is asserted, with no clock needed. Reset takes priority over the chip-select gating. Release goes through a synchronizer, so the registers leave reset cleanly on a clock edge. If the inputs are low while reset is released, the outputs stay low without a glitch.

Top module: `csGatedRegBuf`

## Requirements
- R1: While `rstN` is low, every output (`qData`, `qOdt`, `qCke`, `qCs`) is zero. This takes effect without waiting for a clock edge.
- R2: After reset has been released, a rising edge at which at least one bit of `csIn` is low (patterns 00, 01 or 10) loads `qData` with the `dIn` value present at that edge.
- R3: After reset has been released, a rising edge at which every bit of `csIn` is high (pattern 11) leaves `qData` unchanged, whatever `dIn` is.
- R4: After reset has been released, every rising edge loads `qOdt`, `qCke` and `qCs` from `odtIn`, `ckeIn` and `csIn`, for all four chip-select patterns.
- R5: Release of `rstN` is synchronized through two flops. All outputs stay zero through the first two rising edges after `rstN` goes high, and the first capture happens on the third edge. Outputs therefore stay low across the release, with no glitch, when the inputs are low.
- R6: Reset overrides the gating. Asserting `rstN` low clears `qData` even when `csIn` is 11 and the data outputs are being held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rstN | input | 1 | Active-low reset: asserts at once, releases in sync with the clock |
| dIn | input | 22 | Command/address data inputs |
| odtIn | input | 2 | On-die-termination inputs |
| ckeIn | input | 2 | Clock-enable inputs |
| csIn | input | 2 | Chip-select inputs, active low |
| qData | output | 22 | Registered data, held while all chip selects are high |
| qOdt | output | 2 | Registered termination bits |
| qCke | output | 2 | Registered clock-enable bits |
| qCs | output | 2 | Registered chip-select bits |

## Verification
The bench applies all four chip-select patterns with changing data. A design that gated on only one select, or that treated the gate as active high, would update or hold `qData` on the wrong edges. The bench also checks that the control outputs still update while the data is held; a design that applied the gate to every output would freeze them. Reset is asserted in the middle of a cycle while the data outputs are held, which catches a reset that is synchronous or that loses to the gating. Reset is then released with high data inputs, which exposes a synchronizer with the wrong depth or a release that captures one edge early.

// File: rtl/bufPkg.sv
package bufPkg;
  typedef struct packed {
    logic loadData;
    logic loadCtrl;
  } strobeT;
endpackage

// File: rtl/bufCtrl.sv
module bufCtrl #(
  parameter int CS_W        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CS_W-1:0]   csIn,
  output logic              rstReadyN,
  output bufPkg::strobeT    strobe
);
  logic [SYNC_STAGES-1:0] syncChain;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], 1'b1};
  end

  assign rstReadyN = syncChain[SYNC_STAGES-1];

  // Data is frozen only when every chip select is deasserted (high)
  always_comb begin
    strobe.loadData = ~(&csIn);
    strobe.loadCtrl = 1'b1;
  end
endmodule

// File: rtl/bufDatapath.sv
module bufDatapath #(
  parameter int DATA_W = 22,
  parameter int ODT_W  = 2,
  parameter int CKE_W  = 2,
  parameter int CS_W   = 2
) (
  input  logic                 clk,
  input  logic                 rstReadyN,
  input  bufPkg::strobeT       strobe,
  input  logic [DATA_W-1:0]    dIn,
  input  logic [ODT_W-1:0]     odtIn,
  input  logic [CKE_W-1:0]     ckeIn,
  input  logic [CS_W-1:0]      csIn,
  output logic [DATA_W-1:0]    qData,
  output logic [ODT_W-1:0]     qOdt,
  output logic [CKE_W-1:0]     qCke,
  output logic [CS_W-1:0]      qCs
);
  localparam int CTRL_W = ODT_W + CKE_W + CS_W;

  logic [CTRL_W-1:0] ctrlReg;

  always_ff @(posedge clk or negedge rstReadyN) begin
    if (!rstReadyN)           qData <= '0;
    else if (strobe.loadData) qData <= dIn;
  end

  always_ff @(posedge clk or negedge rstReadyN) begin
    if (!rstReadyN)           ctrlReg <= '0;
    else if (strobe.loadCtrl) ctrlReg <= {odtIn, ckeIn, csIn};
  end

  assign qOdt = ctrlReg[CTRL_W-1 -: ODT_W];
  assign qCke = ctrlReg[CS_W+CKE_W-1 -: CKE_W];
  assign qCs  = ctrlReg[CS_W-1:0];
endmodule

// File: rtl/csGatedRegBuf.sv
module csGatedRegBuf #(
  parameter int DATA_W      = 22,
  parameter int ODT_W       = 2,
  parameter int CKE_W       = 2,
  parameter int CS_W        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dIn,
  input  logic [ODT_W-1:0]  odtIn,
  input  logic [CKE_W-1:0]  ckeIn,
  input  logic [CS_W-1:0]   csIn,
  output logic [DATA_W-1:0] qData,
  output logic [ODT_W-1:0]  qOdt,
  output logic [CKE_W-1:0]  qCke,
  output logic [CS_W-1:0]   qCs
);
  bufPkg::strobeT strobe;
  logic           rstReadyN;

  bufCtrl #(.CS_W(CS_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .csIn(csIn),
    .rstReadyN(rstReadyN), .strobe(strobe)
  );

  bufDatapath #(.DATA_W(DATA_W), .ODT_W(ODT_W), .CKE_W(CKE_W), .CS_W(CS_W)) uData (
    .clk(clk), .rstReadyN(rstReadyN), .strobe(strobe),
    .dIn(dIn), .odtIn(odtIn), .ckeIn(ckeIn), .csIn(csIn),
    .qData(qData), .qOdt(qOdt), .qCke(qCke), .qCs(qCs)
  );
endmodule

// File: rtl/csGatedRegBufChk.sv
module csGatedRegBufChk #(
  parameter int DATA_W = 22,
  parameter int ODT_W  = 2,
  parameter int CKE_W  = 2,
  parameter int CS_W   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              rstReadyN,
  input logic [DATA_W-1:0] dIn,
  input logic [ODT_W-1:0]  odtIn,
  input logic [CKE_W-1:0]  ckeIn,
  input logic [CS_W-1:0]   csIn,
  input logic [DATA_W-1:0] qData,
  input logic [ODT_W-1:0]  qOdt,
  input logic [CKE_W-1:0]  qCke,
  input logic [CS_W-1:0]   qCs
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    !rstN |-> (qData == '0 && qOdt == '0 && qCke == '0 && qCs == '0));

  // R5
  release_window_low_chk: assert property (@(posedge clk)
    !rstReadyN |-> (qData == '0 && qOdt == '0 && qCke == '0 && qCs == '0));

  // R2
  data_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstReadyN && !(&csIn)) |=> qData == $past(dIn));

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstReadyN && (&csIn)) |=> $stable(qData));

  // R4
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReadyN |=> (qOdt == $past(odtIn) && qCke == $past(ckeIn) && qCs == $past(csIn)));
endmodule

bind csGatedRegBuf csGatedRegBufChk #(
  .DATA_W(DATA_W), .ODT_W(ODT_W), .CKE_W(CKE_W), .CS_W(CS_W)
) uChk (
  .clk(clk), .rstN(rstN), .rstReadyN(rstReadyN),
  .dIn(dIn), .odtIn(odtIn), .ckeIn(ckeIn), .csIn(csIn),
  .qData(qData), .qOdt(qOdt), .qCke(qCke), .qCs(qCs)
);

// File: tb/tb_csGatedRegBuf.sv
`timescale 1ns/1ps
module tb_csGatedRegBuf;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [21:0] dIn = '0;
  logic [1:0]  odtIn = '0, ckeIn = '0, csIn = '0;
  logic [21:0] qData;
  logic [1:0]  qOdt, qCke, qCs;

  int vecCount = 0;
  int errCount = 0;
  bit done = 0;

  // reference model state
  logic [21:0] mData = '0;
  logic [1:0]  mOdt = '0, mCke = '0, mCs = '0;
  int          relCount = 0;
  string       dataTag = "R1";
  string       ctrlTag = "R1";

  csGatedRegBuf dut (
    .clk(clk), .rstN(rstN), .dIn(dIn), .odtIn(odtIn), .ckeIn(ckeIn), .csIn(csIn),
    .qData(qData), .qOdt(qOdt), .qCke(qCke), .qCs(qCs)
  );

  always #5 clk = ~clk;

  // Behavioural model: outputs follow inputs once two edges have passed since release
  always @(posedge clk) begin
    if (rstN) begin
      if (relCount >= 2) begin
        mOdt = odtIn; mCke = ckeIn; mCs = csIn;
        ctrlTag = "R4";
        if (csIn != 2'b11) begin mData = dIn; dataTag = "R2"; end
        else dataTag = "R3";
      end else begin
        dataTag = "R5"; ctrlTag = "R5";
        relCount++;
      end
    end
  end

  always @(negedge rstN) begin
    mData = '0; mOdt = '0; mCke = '0; mCs = '0;
    relCount = 0; dataTag = "R1"; ctrlTag = "R1";
  end

  task automatic checkVal(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    checkVal(dataTag, "qData", {10'd0, qData}, {10'd0, mData});
    checkVal(ctrlTag, "qOdt", {30'd0, qOdt}, {30'd0, mOdt});
    checkVal(ctrlTag, "qCke", {30'd0, qCke}, {30'd0, mCke});
    checkVal(ctrlTag, "qCs",  {30'd0, qCs},  {30'd0, mCs});
  endtask

  // one cycle: sample at falling edge, then drive new inputs
  task automatic stepCycle(logic [1:0] cs, logic [21:0] d);
    @(negedge clk);
    compareAll();
    csIn = cs; dIn = d;
    odtIn = 2'($urandom); ckeIn = 2'($urandom);
  endtask

  initial begin
    // R1: reset state
    #2;
    checkVal("R1", "qData at reset", {10'd0, qData}, 32'd0);
    checkVal("R1", "qCs at reset", {30'd0, qCs}, 32'd0);
    repeat (3) @(negedge clk);
    dIn = '0; csIn = 2'b00;
    rstN = 1'b1;
    // R5: low inputs across release stay low
    for (int i = 0; i < 4; i++) stepCycle(2'b00, '0);
    // R2/R3/R4: each chip-select pattern in turn
    for (int i = 0; i < 40; i++) stepCycle(2'(i % 4), 22'($urandom));
    // R3: long hold stretch
    stepCycle(2'b01, 22'h2AAAAA);
    for (int i = 0; i < 10; i++) stepCycle(2'b11, 22'($urandom));
    // random phase
    for (int i = 0; i < 300; i++) stepCycle(2'($urandom), 22'($urandom));
    // R6: reset mid-cycle while data is held with nonzero value
    stepCycle(2'b10, 22'h3FFFFF);
    stepCycle(2'b11, 22'h155555);
    @(posedge clk); #2;
    rstN = 1'b0;
    #1;
    checkVal("R6", "qData cleared over hold", {10'd0, qData}, 32'd0);
    checkVal("R1", "qOdt async clear", {30'd0, qOdt}, 32'd0);
    checkVal("R1", "qCke async clear", {30'd0, qCke}, 32'd0);
    // R1: reset dominates with CS low and data high
    for (int i = 0; i < 3; i++) stepCycle(2'b00, 22'h3FFFFF);
    // R5: release with high data; first capture on third edge
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 5; i++) stepCycle(2'b00, 22'h3FFFFF);
    for (int i = 0; i < 100; i++) stepCycle(2'($urandom), 22'($urandom));
    @(negedge clk);
    compareAll();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      vecCount++; errCount++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end
endmodule